// File: doc/BRIEF.md
# Paged-Coefficient 3x3 Image Convolver

This block computes a 3x3 two-dimensional convolution on signed 8-bit pixels. A vertical column of three pixels arrives on three row ports at once. The block keeps the last three captured columns as its window, multiplies the nine pixels by nine signed 8-bit weights, and presents the full-precision sum as a registered 20-bit signed result. It produces one result per three-cycle data period.

The weights are stored in four pages of nine entries each. While the active-low load strobe `ld_n` is low, `cfg_data` carries a weight value and `cfg_addr` carries the write location and a mode flag. When `ld_n` returns high, the block resynchronizes its three-cycle cadence to that edge. A 2-bit read-page input selects the weight page. In the staggered mode, the read page is taken column by column on three successive edges, so a page can change partway through the data stream. In the broadcast mode, all three columns take the page present on the capture edge. Either way, software can rewrite one page while another page is being read.

Top module: `paged_conv3x3`

## Requirements
- R1: A synchronous active-high `rst` clears `sum_out` to 0, `sum_vld` to 0, the mode flag to staggered (0), the cadence phase, the window and every weight in all four pages to 0.
- R2: On a rising edge with `ld_n` low and `cfg_addr[3:0]` in 0..8, the weight at page `cfg_addr[5:4]` and index `cfg_addr[3:0]` takes the value of `cfg_data`. Index k is the weight for row k/3 and column k%3.
- R3: A write with `cfg_addr[3:0]` in 9..15 changes no weight.
- R4: While `ld_n` is high, no weight changes, whatever the values on `cfg_addr` and `cfg_data`.
- R5: A rising edge that samples `ld_n` high, after the previous edge sampled it low, is a capture edge. Captures then recur on every third edge after it.
- R6: Pixels are taken only on capture edges. The new column (`row0`, `row1`, `row2` as rows 0..2) becomes column 2 of the window, and the older columns shift toward column 0.
- R7: On the third edge after a capture, with no resynchronization in between, `sum_out` takes the signed sum of the nine products pixel(row,col) x weight(row,col). It is exact in 20 bits. `sum_vld` is high for exactly that one following cycle.
- R8: In staggered mode, the weights of column 0 come from the page on `rd_page` at the capture edge. Column 1 uses the page at the next edge and column 2 the page at the edge after that.
- R9: In broadcast mode, all three columns use the page on `rd_page` at the capture edge. Later changes of `rd_page` within the period have no effect.
- R10: Every edge with `ld_n` low sets the mode flag from `cfg_addr[6]`: 1 selects broadcast and 0 selects staggered.
- R11: If a resynchronizing edge occurs before the third edge after a capture, the pending result is dropped. `sum_vld` stays low and `sum_out` keeps its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| ld_n | input | 1 | Active-low weight load strobe; its rising edge resynchronizes |
| cfg_addr | input | 7 | Write index [3:0], write page [5:4], mode flag [6] |
| cfg_data | input | 8 | Weight value to write |
| rd_page | input | 2 | Weight page to read |
| row0 | input | 8 | Pixel of row 0, two's complement |
| row1 | input | 8 | Pixel of row 1, two's complement |
| row2 | input | 8 | Pixel of row 2, two's complement |
| sum_out | output | 20 | Registered signed convolution sum |
| sum_vld | output | 1 | One-cycle strobe marking a new `sum_out` |

## Verification
The assertions assume that `rst` is held for at least one edge before any check matters. They also assume that `ld_n` is a clean level sampled on each edge, so every low-to-high step counts as a resynchronization. The bench writes no weights while a period whose result it checks is in flight. It moves `ld_n` low only in programming bursts or in the deliberate early-resync case, and it changes `rd_page` only on the edges that the selected mode samples or deliberately ignores. Pixels, pages and the idle values on the write port are drawn at random inside those limits. Directed cases add all-minimum operands and a resync in mid-period.

// File: rtl/conv3_pkg.sv
package conv3_pkg;
  localparam int TAPS  = 3;
  localparam int NCOEF = TAPS * TAPS;
endpackage

// File: rtl/conv3_cadence.sv
module conv3_cadence (
  input  logic       clk,
  input  logic       rst,
  input  logic       ld_n,
  output logic [1:0] phase,
  output logic       capture,
  output logic       last
);
  logic ld_q;

  assign last    = (phase == 2'd2);
  assign capture = (ld_n & ~ld_q) | last;

  always_ff @(posedge clk) begin
    ld_q <= ld_n;
    if (rst)          phase <= 2'd0;
    else if (capture) phase <= 2'd0;
    else              phase <= phase + 2'd1;
  end

  // R5: phase never leaves 0..2
  p_phase_range_r5: assert property (@(posedge clk) disable iff (rst)
    phase != 2'd3);

  // R5: a rising load strobe restarts the period
  p_resync_r5: assert property (@(posedge clk) disable iff (rst)
    $rose(ld_n) |=> (phase == 2'd0));
endmodule

// File: rtl/conv3_bank.sv
module conv3_bank #(
  parameter int PAGES = 4,
  parameter int W     = 8
) (
  input  logic                                        clk,
  input  logic                                        rst,
  input  logic                                        wr_en,
  input  logic [$clog2(PAGES)-1:0]                    wr_page,
  input  logic [$clog2(conv3_pkg::NCOEF)-1:0]         wr_idx,
  input  logic [W-1:0]                                wr_val,
  input  logic [conv3_pkg::TAPS-1:0][$clog2(PAGES)-1:0] rd_pg,
  output logic [conv3_pkg::NCOEF-1:0][W-1:0]          coefs
);
  import conv3_pkg::*;
  localparam int IDXW = $clog2(NCOEF);
  localparam logic [IDXW-1:0] IDX_LIM = IDXW'(NCOEF);

  logic [PAGES-1:0][NCOEF-1:0][W-1:0] bank;

  always_ff @(posedge clk) begin
    if (rst) bank <= '0;
    else if (wr_en && (wr_idx < IDX_LIM)) bank[wr_page][wr_idx] <= wr_val;
  end

  for (genvar c = 0; c < TAPS; c++) begin : g_col
    for (genvar r = 0; r < TAPS; r++) begin : g_row
      assign coefs[r*TAPS+c] = bank[rd_pg[c]][r*TAPS+c];
    end
  end

  // R4: weights hold while the strobe is inactive
  p_hold_r4: assert property (@(posedge clk) disable iff (rst)
    !wr_en |=> $stable(bank));

  // R3: out-of-range indices leave every page alone
  p_ignore_idx_r3: assert property (@(posedge clk) disable iff (rst)
    (wr_en && (wr_idx >= IDX_LIM)) |=> $stable(bank));
endmodule

// File: rtl/conv3_mac.sv
module conv3_mac #(
  parameter int W     = 8,
  parameter int SUM_W = 20
) (
  input  logic                                   clk,
  input  logic                                   rst,
  input  logic                                   capture,
  input  logic                                   fire,
  input  logic [conv3_pkg::TAPS-1:0][W-1:0]      pix_in,
  input  logic [conv3_pkg::NCOEF-1:0][W-1:0]     coefs,
  output logic signed [SUM_W-1:0]                sum_out,
  output logic                                   sum_vld
);
  import conv3_pkg::*;

  logic [TAPS-1:0][TAPS-1:0][W-1:0] win;
  logic signed [SUM_W-1:0] acc;
  logic signed [2*W-1:0]   prod;

  always_ff @(posedge clk) begin
    if (rst) win <= '0;
    else if (capture) begin
      for (int c = 0; c < TAPS-1; c++) win[c] <= win[c+1];
      win[TAPS-1] <= pix_in;
    end
  end

  always_comb begin
    acc  = '0;
    prod = '0;
    for (int c = 0; c < TAPS; c++) begin
      for (int r = 0; r < TAPS; r++) begin
        prod = $signed(win[c][r]) * $signed(coefs[r*TAPS+c]);
        acc  = acc + SUM_W'(prod);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sum_out <= '0;
      sum_vld <= 1'b0;
    end else begin
      sum_vld <= fire;
      if (fire) sum_out <= acc;
    end
  end

  // R7: strobes are at least a period apart
  p_vld_gap_r7: assert property (@(posedge clk) disable iff (rst)
    sum_vld |=> !sum_vld);

  // R11: the result only moves together with its strobe
  p_sum_hold_r11: assert property (@(posedge clk) disable iff (rst)
    !$stable(sum_out) |-> sum_vld);
endmodule

// File: rtl/paged_conv3x3.sv
module paged_conv3x3 #(
  parameter int W     = 8,
  parameter int PAGES = 4,
  parameter int SUM_W = 20
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     ld_n,
  input  logic [6:0]               cfg_addr,
  input  logic [W-1:0]             cfg_data,
  input  logic [$clog2(PAGES)-1:0] rd_page,
  input  logic [W-1:0]             row0,
  input  logic [W-1:0]             row1,
  input  logic [W-1:0]             row2,
  output logic [SUM_W-1:0]         sum_out,
  output logic                     sum_vld
);
  import conv3_pkg::*;
  localparam int PW       = $clog2(PAGES);
  localparam int IDXW     = $clog2(NCOEF);
  localparam int PAGE_LSB = IDXW;
  localparam int MODE_BIT = IDXW + PW;

  logic [1:0] phase;
  logic       capture, last;
  logic       bcast_q;
  logic [TAPS-1:0][PW-1:0] col_pg;
  logic [NCOEF-1:0][W-1:0] coefs;
  logic signed [SUM_W-1:0] sum_s;

  conv3_cadence u_cad (
    .clk(clk), .rst(rst), .ld_n(ld_n),
    .phase(phase), .capture(capture), .last(last)
  );

  always_ff @(posedge clk) begin
    if (rst)        bcast_q <= 1'b0;
    else if (!ld_n) bcast_q <= cfg_addr[MODE_BIT];
  end

  for (genvar c = 0; c < TAPS; c++) begin : g_pg
    always_ff @(posedge clk) begin
      if (rst) col_pg[c] <= '0;
      else if (capture) begin
        if (c == 0 || bcast_q) col_pg[c] <= rd_page;
      end else if (!bcast_q && c > 0 && phase == 2'(c-1)) begin
        col_pg[c] <= rd_page;
      end
    end
  end

  conv3_bank #(.PAGES(PAGES), .W(W)) u_bank (
    .clk(clk), .rst(rst),
    .wr_en(!ld_n),
    .wr_page(cfg_addr[PAGE_LSB +: PW]),
    .wr_idx(cfg_addr[IDXW-1:0]),
    .wr_val(cfg_data),
    .rd_pg(col_pg),
    .coefs(coefs)
  );

  conv3_mac #(.W(W), .SUM_W(SUM_W)) u_mac (
    .clk(clk), .rst(rst),
    .capture(capture), .fire(last),
    .pix_in({row2, row1, row0}),
    .coefs(coefs),
    .sum_out(sum_s), .sum_vld(sum_vld)
  );

  assign sum_out = sum_s;

  // R8: column 0 page moves only on capture edges
  p_col0_r8: assert property (@(posedge clk) disable iff (rst)
    !capture |=> $stable(col_pg[0]));

  // R9: broadcast mode freezes every column page between captures
  p_bcast_r9: assert property (@(posedge clk) disable iff (rst)
    (bcast_q && !capture) |=> $stable(col_pg));
endmodule

// File: tb/sim_paged_conv3x3.sv
module sim_paged_conv3x3;
  logic clk = 1'b0;
  logic rst, ld_n;
  logic [6:0] cfg_addr;
  logic [7:0] cfg_data, row0, row1, row2;
  logic [1:0] rd_page;
  logic [19:0] sum_out;
  logic sum_vld;

  int checks = 0, errors = 0;
  bit done = 0;

  logic [7:0] cm [4][9];
  logic [7:0] win_m [3][3];
  bit mode_m;
  int hp;
  int pexp;
  string ptag;

  always #4 clk = ~clk;

  paged_conv3x3 u0 (
    .clk(clk), .rst(rst), .ld_n(ld_n), .cfg_addr(cfg_addr), .cfg_data(cfg_data),
    .rd_page(rd_page), .row0(row0), .row1(row1), .row2(row2),
    .sum_out(sum_out), .sum_vld(sum_vld)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int conv(input logic [1:0] q0, input logic [1:0] q1, input logic [1:0] q2);
    int s;
    logic [1:0] q [3];
    s = 0;
    q[0] = q0; q[1] = q1; q[2] = q2;
    for (int c = 0; c < 3; c++)
      for (int r = 0; r < 3; r++)
        s = s + $signed(win_m[c][r]) * $signed(cm[q[c]][r*3+c]);
    return s;
  endfunction

  // starts and ends just after a falling edge
  task automatic wr(input logic [1:0] pg, input logic [3:0] idx, input logic [7:0] v);
    ld_n = 1'b0;
    cfg_addr = {mode_m, pg, idx};
    cfg_data = v;
    row0 = 8'd0; row1 = 8'd0; row2 = 8'd0;
    if (idx < 4'd9) cm[pg][idx] = v;
    @(posedge clk); @(negedge clk);
  endtask

  task automatic flush();
    for (int i = 0; i < 9; i++) wr(2'($urandom), 4'hF, 8'($urandom));
    for (int c = 0; c < 3; c++) for (int r = 0; r < 3; r++) win_m[c][r] = 8'd0;
    hp = 0;
  endtask

  task automatic period(input logic [7:0] a, input logic [7:0] b, input logic [7:0] c,
                        input logic [1:0] p0, input logic [1:0] p1, input logic [1:0] p2,
                        input bit early, input string tg);
    int e;
    ld_n = 1'b1;
    cfg_addr = 7'($urandom); cfg_data = 8'($urandom);
    row0 = a; row1 = b; row2 = c;
    rd_page = p0;
    win_m[0] = win_m[1]; win_m[1] = win_m[2];
    win_m[2][0] = a; win_m[2][1] = b; win_m[2][2] = c;
    e = mode_m ? conv(p0, p0, p0) : conv(p0, p1, p2);
    @(posedge clk); @(negedge clk);
    if (hp == 1) begin
      chk(sum_vld == 1'b1, {ptag, " R7 strobe"}, int'(sum_vld), 1);
      chk($signed(sum_out) == pexp, {ptag, " R7 sum"}, int'($signed(sum_out)), pexp);
    end else if (hp == 2) begin
      chk(sum_vld == 1'b0, "R11 dropped result", int'(sum_vld), 0);
    end
    rd_page = p1;
    row0 = 8'($urandom); row1 = 8'($urandom); row2 = 8'($urandom);
    cfg_addr = 7'($urandom); cfg_data = 8'($urandom);
    if (early) begin
      ld_n = 1'b0;
      cfg_addr = {mode_m, 2'd0, 4'hF};
    end
    @(posedge clk); @(negedge clk);
    chk(sum_vld == 1'b0, "R7 no strobe mid-period", int'(sum_vld), 0);
    if (early) begin
      ld_n = 1'b1;
      hp = 2;
      return;
    end
    rd_page = p2;
    row0 = 8'($urandom); row1 = 8'($urandom); row2 = 8'($urandom);
    @(posedge clk); @(negedge clk);
    chk(sum_vld == 1'b0, "R6 R7 no strobe mid-period", int'(sum_vld), 0);
    pexp = e; ptag = tg; hp = 1;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    for (int p = 0; p < 4; p++) for (int i = 0; i < 9; i++) cm[p][i] = 8'd0;
    rst = 1'b1; ld_n = 1'b1; cfg_addr = '0; cfg_data = '0; rd_page = '0;
    row0 = '0; row1 = '0; row2 = '0;
    mode_m = 1'b0; hp = 0; pexp = 0; ptag = "";
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(sum_vld == 1'b0, "R1 reset strobe", int'(sum_vld), 0);
    chk(sum_out == 20'd0, "R1 reset sum", int'(sum_out), 0);
    rst = 1'b0;

    // R1: cleared pages give zero sums
    flush();
    for (int k = 0; k < 5; k++)
      period(8'($urandom), 8'($urandom), 8'($urandom), 2'($urandom), 2'($urandom),
             2'($urandom), 1'b0, "R1 cleared pages");

    // R2 R3: load all pages, then junk at indices 9..15
    for (int p = 0; p < 4; p++)
      for (int i = 0; i < 9; i++) wr(2'(p), 4'(i), 8'($urandom));
    for (int i = 9; i < 16; i++) wr(2'd1, 4'(i), 8'($urandom));
    for (int i = 0; i < 9; i++) wr(2'd3, 4'(i), 8'h80);
    flush();
    for (int k = 0; k < 24; k++)
      period(8'($urandom), 8'($urandom), 8'($urandom), 2'($urandom), 2'($urandom),
             2'($urandom), 1'b0, "R2 R3 R4 R6 R8 staggered");

    // R7: extreme operands, -128 * -128 nine times
    for (int k = 0; k < 4; k++)
      period(8'h80, 8'h80, 8'h80, 2'd3, 2'd3, 2'd3, 1'b0, "R7 extreme");
    chk(pexp == 147456, "R7 extreme model", pexp, 147456);

    // R5 R11: resync in mid-period
    period(8'($urandom), 8'($urandom), 8'($urandom), 2'd0, 2'd1, 2'd2, 1'b1, "R11");
    for (int k = 0; k < 4; k++)
      period(8'($urandom), 8'($urandom), 8'($urandom), 2'($urandom), 2'($urandom),
             2'($urandom), 1'b0, "R5 after resync");

    // R9 R10: broadcast mode
    mode_m = 1'b1;
    flush();
    for (int k = 0; k < 14; k++)
      period(8'($urandom), 8'($urandom), 8'($urandom), 2'($urandom), 2'($urandom),
             2'($urandom), 1'b0, "R9 R10 broadcast");

    // R10: back to staggered
    mode_m = 1'b0;
    flush();
    for (int k = 0; k < 6; k++)
      period(8'($urandom), 8'($urandom), 8'($urandom), 2'($urandom), 2'($urandom),
             2'($urandom), 1'b0, "R8 R10 staggered again");

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule